// File: doc/BRIEF.md
# Program Status and Exception-Entry Unit

This unit holds a processor's current status word and one saved status word for each exception mode. It applies every atomic change that the status word can undergo. Exception entry saves the old status into the target mode's saved slot and rewrites the mode, the mask bits, the state bit and the endian bit. A status write can replace the whole word or only its low control byte. A change-state command sets or clears interrupt masks and can load a new mode. An exception return restores the saved word of the current mode.

The vector address and a one-cycle load pulse come out together, so the fetch side can redirect the program counter. The return-load pulse tells the fetch side to take the link value in the same cycle that the status is restored. The bank index output tells the register file which set of stack and link registers is active.

Status word layout: bits [4:0] mode, bit 5 instruction-set state, bit 6 fast-interrupt mask, bit 7 interrupt mask, bit 8 imprecise-abort mask, bit 9 endianness. Mode codes: user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F.

Top module: `psr_unit`

## Requirements
- R1: After reset the status is 0x000001D3 (supervisor mode, all three masks set, state bit and endian bit clear). The vector address is 0, all pulse outputs are 0, and the saved output is 0.
- R2: The exception type code selects the target mode and the vector, relative to VEC_BASE: 0 reset goes to supervisor at 0x00, 1 undefined to undefined at 0x04, 2 software interrupt to supervisor at 0x08, 3 prefetch abort to abort at 0x0C, 4 data abort to abort at 0x10, 5 interrupt to interrupt at 0x18, and 6 fast interrupt to fast interrupt at 0x1C. The vector appears with vec_load_o high for exactly one cycle after the request edge.
- R3: On exception entry, bit 5 is cleared and bit 7 is set. Bit 6 is set only for types 0 and 6 and is otherwise unchanged. Bit 8 is set for every type except 1 and 2, which leave it unchanged. Bit 9 takes cfg_big_endian. All bits from 10 upward are unchanged.
- R4: On exception entry, the target mode's saved word receives the full prior status. The saved words of all other modes are unchanged.
- R5: Type code 7 is reserved; a request with it changes no state and gives no vector pulse.
- R6: A status write with wr_ctrl_only high changes only bits [7:0]. With wr_ctrl_only low it replaces the whole word.
- R7: In user mode a status write cannot alter bits [4:0] or bits [8:6]; the other selected bits are still written.
- R8: A change-state command sets (cps_disable=1) or clears (cps_disable=0) bit 7 and/or bit 6 as selected, and loads cps_mode when cps_mode_en is high. In user mode the command has no effect.
- R9: A return copies the current mode's saved word into the status and pulses ret_load_o for one cycle.
- R10: A return in user or system mode changes nothing and pulses ret_ignored_o for one cycle instead of ret_load_o.
- R11: When several commands arrive in one cycle, the priority is exception request, then return, then change-state, then status write. Only the winner takes effect.
- R12: bank_o encodes the current mode: 0 user/system, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined. saved_o shows the saved word of that bank, and 0 for bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request |
| exc_type | input | 3 | Exception type code |
| cfg_big_endian | input | 1 | Endian value loaded on exception entry |
| wr_en | input | 1 | Status write strobe |
| wr_ctrl_only | input | 1 | Restrict write to bits [7:0] |
| wr_data | input | PSR_W | Status write data |
| cps_en | input | 1 | Change-state command |
| cps_disable | input | 1 | 1 sets selected masks, 0 clears them |
| cps_sel_irq | input | 1 | Apply to interrupt mask (bit 7) |
| cps_sel_fiq | input | 1 | Apply to fast-interrupt mask (bit 6) |
| cps_mode_en | input | 1 | Also load a new mode |
| cps_mode | input | 5 | Mode to load |
| ret_en | input | 1 | Exception return command |
| status_o | output | PSR_W | Current status word |
| saved_o | output | PSR_W | Saved word of the current bank |
| vec_addr_o | output | ADDR_W | Last exception vector |
| vec_load_o | output | 1 | Vector valid pulse |
| ret_load_o | output | 1 | Return accepted pulse |
| ret_ignored_o | output | 1 | Return rejected pulse |
| bank_o | output | 3 | Register bank index |

## Verification
The bench builds the unit with a 32-bit status word, a 32-bit address and a zero vector base, so the vector table is compared as plain small constants. At this size every type code, including the reserved one, can be tried from each of the six privileged modes, with both endian settings and four mask and state patterns. Each case is followed by a return, so every saved slot is filled and read back many times. Directed sequences then cover the control-byte write, the change-state forms, user-mode lockout, rejected returns and the command priority order.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int MODE_W = 5;
    localparam int NBANKS = 6;
    localparam int BANK_W = $clog2(NBANKS);

    localparam int B_T = 5;
    localparam int B_F = 6;
    localparam int B_I = 7;
    localparam int B_A = 8;
    localparam int B_E = 9;

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    typedef enum logic [2:0] {
        EXC_RESET = 3'd0,
        EXC_UNDEF = 3'd1,
        EXC_SWI   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_IRQ   = 3'd5,
        EXC_FIQ   = 3'd6,
        EXC_RSVD  = 3'd7
    } exc_e;

    typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/psr_exc_decode.sv
module psr_exc_decode
    import psr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic [2:0]        kind,
    output logic              valid,
    output logic [MODE_W-1:0] mode,
    output logic [ADDR_W-1:0] vec,
    output logic              sets_f,
    output logic              sets_a
);
    localparam int SLOT_W = 4;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        valid  = 1'b1;
        sets_f = 1'b0;
        sets_a = 1'b1;
        mode   = MODE_SVC;
        unique case (exc_e'(kind))
            EXC_RESET: sets_f = 1'b1;
            EXC_UNDEF: begin mode = MODE_UND; sets_a = 1'b0; end
            EXC_SWI:   sets_a = 1'b0;
            EXC_PABT:  mode = MODE_ABT;
            EXC_DABT:  mode = MODE_ABT;
            EXC_IRQ:   mode = MODE_IRQ;
            EXC_FIQ:   begin mode = MODE_FIQ; sets_f = 1'b1; end
            default:   begin valid = 1'b0; sets_a = 1'b0; end
        endcase
        // one slot is skipped between data abort and interrupt
        slot = (kind >= 3'd5) ? SLOT_W'(kind) + SLOT_W'(1) : SLOT_W'(kind);
        vec  = VEC_BASE + (ADDR_W'(slot) << 2);
    end
endmodule

// File: rtl/psr_bank_decode.sv
module psr_bank_decode
    import psr_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_t             bank,
    output logic              priv
);
    always_comb begin
        unique case (mode)
            MODE_FIQ: bank = bank_t'(1);
            MODE_IRQ: bank = bank_t'(2);
            MODE_SVC: bank = bank_t'(3);
            MODE_ABT: bank = bank_t'(4);
            MODE_UND: bank = bank_t'(5);
            default:  bank = bank_t'(0);
        endcase
        priv = (mode != MODE_USR);
    end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int PSR_W  = 32,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [2:0]        exc_type,
    input  logic              cfg_big_endian,
    input  logic              wr_en,
    input  logic              wr_ctrl_only,
    input  logic [PSR_W-1:0]  wr_data,
    input  logic              cps_en,
    input  logic              cps_disable,
    input  logic              cps_sel_irq,
    input  logic              cps_sel_fiq,
    input  logic              cps_mode_en,
    input  logic [4:0]        cps_mode,
    input  logic              ret_en,
    output logic [PSR_W-1:0]  status_o,
    output logic [PSR_W-1:0]  saved_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              vec_load_o,
    output logic              ret_load_o,
    output logic              ret_ignored_o,
    output logic [2:0]        bank_o
);
    localparam logic [PSR_W-1:0] RESET_PSR = PSR_W'(32'h0000_01D3);
    localparam logic [PSR_W-1:0] CTRL_MASK = PSR_W'(32'h0000_00FF);
    localparam logic [PSR_W-1:0] PROT_MASK = PSR_W'(32'h0000_01DF);

    typedef struct packed {
        logic [PSR_W-1:0]                 cpsr;
        logic [NBANKS-1:0][PSR_W-1:0]     spsr;
        logic [ADDR_W-1:0]                vec;
        logic                             vec_load;
        logic                             ret_load;
        logic                             ret_ign;
    } state_t;

    state_t s_d, s_q;

    logic              ex_valid, ex_sets_f, ex_sets_a;
    logic [MODE_W-1:0] ex_mode;
    logic [ADDR_W-1:0] ex_vec;
    bank_t             ex_bank, cur_bank;
    logic              ex_priv_unused, cur_priv;
    logic [PSR_W-1:0]  wmask, entry_psr;

    psr_exc_decode #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_exc (
        .kind(exc_type), .valid(ex_valid), .mode(ex_mode),
        .vec(ex_vec), .sets_f(ex_sets_f), .sets_a(ex_sets_a)
    );

    psr_bank_decode u_cur_bank (
        .mode(s_q.cpsr[MODE_W-1:0]), .bank(cur_bank), .priv(cur_priv)
    );

    psr_bank_decode u_exc_bank (
        .mode(ex_mode), .bank(ex_bank), .priv(ex_priv_unused)
    );

    always_comb begin
        s_d          = s_q;
        s_d.vec_load = 1'b0;
        s_d.ret_load = 1'b0;
        s_d.ret_ign  = 1'b0;

        entry_psr                = s_q.cpsr;
        entry_psr[MODE_W-1:0]    = ex_mode;
        entry_psr[B_T]           = 1'b0;
        entry_psr[B_I]           = 1'b1;
        entry_psr[B_F]           = s_q.cpsr[B_F] | ex_sets_f;
        entry_psr[B_A]           = s_q.cpsr[B_A] | ex_sets_a;
        entry_psr[B_E]           = cfg_big_endian;

        wmask = wr_ctrl_only ? CTRL_MASK : '1;
        if (!cur_priv) wmask = wmask & ~PROT_MASK;

        if (exc_req && ex_valid) begin
            s_d.spsr[ex_bank] = s_q.cpsr;
            s_d.cpsr          = entry_psr;
            s_d.vec           = ex_vec;
            s_d.vec_load      = 1'b1;
        end else if (exc_req) begin
            s_d = s_d;
        end else if (ret_en) begin
            if (cur_bank == bank_t'(0)) begin
                s_d.ret_ign = 1'b1;
            end else begin
                s_d.cpsr     = s_q.spsr[cur_bank];
                s_d.ret_load = 1'b1;
            end
        end else if (cps_en) begin
            if (cur_priv) begin
                if (cps_sel_irq) s_d.cpsr[B_I] = cps_disable;
                if (cps_sel_fiq) s_d.cpsr[B_F] = cps_disable;
                if (cps_mode_en) s_d.cpsr[MODE_W-1:0] = cps_mode;
            end
        end else if (wr_en) begin
            s_d.cpsr = (s_q.cpsr & ~wmask) | (wr_data & wmask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cpsr <= RESET_PSR;
            s_q.vec  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o      = s_q.cpsr;
    assign saved_o       = s_q.spsr[cur_bank];
    assign vec_addr_o    = s_q.vec;
    assign vec_load_o    = s_q.vec_load;
    assign ret_load_o    = s_q.ret_load;
    assign ret_ignored_o = s_q.ret_ign;
    assign bank_o        = 3'(cur_bank);

    // R3: entry leaves interrupts masked and the state bit clear
    a_r3_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && ex_valid) |=> (status_o[B_I] && !status_o[B_T] && vec_load_o));

    // R4: the target mode's saved slot holds the pre-entry status
    a_r4_saved_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && ex_valid) |=> (saved_o == $past(status_o)));

    // R6: a control-byte write leaves the upper bits alone
    a_r6_ctrl_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctrl_only && !exc_req && !ret_en && !cps_en)
        |=> (status_o[PSR_W-1:8] == $past(status_o[PSR_W-1:8])));

    // R7: user mode is left only through an exception, masks stay put
    a_r7_user_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o[MODE_W-1:0] == MODE_USR) && !(exc_req && ex_valid))
        |=> ((status_o[MODE_W-1:0] == MODE_USR) &&
             (status_o[B_A:B_F] == $past(status_o[B_A:B_F]))));

    // R10: pulses are mutually exclusive
    a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_load_o, ret_load_o, ret_ignored_o}));
endmodule

// File: tb/tb_psr_unit.sv
`timescale 1ns/1ps
module tb_psr_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_req;
    logic [2:0]  exc_type;
    logic        cfg_big_endian;
    logic        wr_en, wr_ctrl_only;
    logic [31:0] wr_data;
    logic        cps_en, cps_disable, cps_sel_irq, cps_sel_fiq, cps_mode_en;
    logic [4:0]  cps_mode;
    logic        ret_en;
    logic [31:0] status_o, saved_o, vec_addr_o;
    logic        vec_load_o, ret_load_o, ret_ignored_o;
    logic [2:0]  bank_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_spsr [6];

    always #4 clk = ~clk;

    psr_unit dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
        .cfg_big_endian(cfg_big_endian), .wr_en(wr_en), .wr_ctrl_only(wr_ctrl_only),
        .wr_data(wr_data), .cps_en(cps_en), .cps_disable(cps_disable),
        .cps_sel_irq(cps_sel_irq), .cps_sel_fiq(cps_sel_fiq),
        .cps_mode_en(cps_mode_en), .cps_mode(cps_mode), .ret_en(ret_en),
        .status_o(status_o), .saved_o(saved_o), .vec_addr_o(vec_addr_o),
        .vec_load_o(vec_load_o), .ret_load_o(ret_load_o),
        .ret_ignored_o(ret_ignored_o), .bank_o(bank_o)
    );

    function automatic logic [4:0] f_tmode(input int t);
        case (t)
            0, 2: return 5'h13;
            1:    return 5'h1B;
            3, 4: return 5'h17;
            5:    return 5'h12;
            default: return 5'h11;
        endcase
    endfunction

    function automatic logic [31:0] f_vec(input int t);
        return (t >= 5) ? 32'((t + 1) * 4) : 32'(t * 4);
    endfunction

    function automatic int f_bank(input logic [4:0] m);
        case (m)
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] f_entry(input logic [31:0] p, input int t, input logic c);
        logic [31:0] e;
        e = p;
        e[4:0] = f_tmode(t);
        e[5] = 1'b0;
        e[7] = 1'b1;
        if (t == 0 || t == 6) e[6] = 1'b1;
        if (t != 1 && t != 2) e[8] = 1'b1;
        e[9] = c;
        return e;
    endfunction

    task automatic idle();
        exc_req = 0; exc_type = 0; wr_en = 0; wr_ctrl_only = 0; wr_data = 0;
        cps_en = 0; cps_disable = 0; cps_sel_irq = 0; cps_sel_fiq = 0;
        cps_mode_en = 0; cps_mode = 0; ret_en = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d, input logic ctrl);
        idle(); wr_en = 1; wr_data = d; wr_ctrl_only = ctrl; tick(); idle();
    endtask

    task automatic do_exc(input int t, input logic c);
        idle(); exc_req = 1; exc_type = 3'(t); cfg_big_endian = c; tick(); idle();
    endtask

    task automatic do_ret();
        idle(); ret_en = 1; tick(); idle();
    endtask

    task automatic do_cps(input logic dis, input logic si, input logic sf,
                          input logic me, input logic [4:0] m);
        idle(); cps_en = 1; cps_disable = dis; cps_sel_irq = si; cps_sel_fiq = sf;
        cps_mode_en = me; cps_mode = m; tick(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0]  sm [6];
        logic [31:0] v, e, prev;
        sm[0] = 5'h13; sm[1] = 5'h12; sm[2] = 5'h11;
        sm[3] = 5'h17; sm[4] = 5'h1B; sm[5] = 5'h1F;
        idle(); cfg_big_endian = 0; rst_n = 0;
        for (int i = 0; i < 6; i++) m_spsr[i] = 32'h0;
        repeat (3) tick();
        rst_n = 1;
        // R1 reset state
        chk("R1 status", status_o, 32'h0000_01D3);
        chk("R1 vec_addr", vec_addr_o, 32'h0);
        chk("R1 pulses", {29'h0, vec_load_o, ret_load_o, ret_ignored_o}, 32'h0);
        chk("R1 saved", saved_o, 32'h0);
        chk("R12 reset bank", {29'h0, bank_o}, 32'd3);

        // sweep: start mode x type x endian x pattern
        for (int si = 0; si < 6; si++)
            for (int t = 0; t < 8; t++)
                for (int c = 0; c < 2; c++)
                    for (int p = 0; p < 4; p++) begin
                        v = 32'h5A3C_0000 ^ (32'(p) << 26) ^ (32'(t) << 14) ^ (32'(si) << 10);
                        v[9] = p[0]; v[8] = p[1]; v[7] = ~p[0];
                        v[6] = p[0] ^ p[1]; v[5] = p[1]; v[4:0] = sm[si];
                        do_write(v, 1'b0);
                        chk("R6 full write", status_o, v);
                        chk("R12 bank", {29'h0, bank_o}, 32'(f_bank(v[4:0])));
                        chk("R4 other slots kept", saved_o,
                            (f_bank(v[4:0]) == 0) ? 32'h0 : m_spsr[f_bank(v[4:0])]);
                        do_exc(t, c[0]);
                        if (t == 7) begin
                            chk("R5 reserved status", status_o, v);
                            chk("R5 reserved no vector", {31'h0, vec_load_o}, 32'h0);
                        end else begin
                            e = f_entry(v, t, c[0]);
                            m_spsr[f_bank(f_tmode(t))] = v;
                            chk("R2 vec_load", {31'h0, vec_load_o}, 32'h1);
                            chk("R2 vector", vec_addr_o, f_vec(t));
                            chk("R3 entry status", status_o, e);
                            chk("R4 saved capture", saved_o, v);
                            do_ret();
                            chk("R9 restored", status_o, v);
                            chk("R9 ret_load", {30'h0, ret_load_o, vec_load_o}, 32'h2);
                        end
                    end

        // R6 control-byte write
        do_write(32'hF000_0213, 1'b0);
        do_write(32'h0000_FFD2, 1'b1);
        chk("R6 ctrl byte", status_o, 32'hF000_02D2);
        // R8 change-state forms
        do_cps(1'b0, 1'b1, 1'b0, 1'b0, 5'h00);
        chk("R8 clear I", status_o, 32'hF000_0252);
        do_cps(1'b1, 1'b1, 1'b1, 1'b1, 5'h1F);
        chk("R8 set I F and mode", status_o, 32'hF000_02DF);
        do_cps(1'b0, 1'b0, 1'b1, 1'b0, 5'h00);
        chk("R8 clear F", status_o, 32'hF000_029F);
        // R10 return in system mode
        do_ret();
        chk("R10 sys status", status_o, 32'hF000_029F);
        chk("R10 sys flag", {30'h0, ret_ignored_o, ret_load_o}, 32'h2);
        tick();
        chk("R10 flag one cycle", {31'h0, ret_ignored_o}, 32'h0);

        // user mode
        do_write(32'h0000_00D0, 1'b0);
        chk("R12 user bank", {29'h0, bank_o}, 32'd0);
        chk("R12 user saved", saved_o, 32'h0);
        do_write(32'hFFFF_FF3F, 1'b0);
        chk("R7 user write", status_o, 32'hFFFF_FEF0);
        do_write(32'h0000_0000, 1'b1);
        chk("R7 user ctrl write", status_o, 32'hFFFF_FED0);
        do_cps(1'b0, 1'b1, 1'b1, 1'b1, 5'h13);
        chk("R8 user cps ignored", status_o, 32'hFFFF_FED0);
        do_ret();
        chk("R10 user status", status_o, 32'hFFFF_FED0);
        chk("R10 user flag", {31'h0, ret_ignored_o}, 32'h1);
        do_exc(5, 1'b0);
        chk("R3 entry from user", status_o, f_entry(32'hFFFF_FED0, 5, 1'b0));
        chk("R4 saved user word", saved_o, 32'hFFFF_FED0);
        do_ret();
        chk("R9 back to user", status_o, 32'hFFFF_FED0);

        // R11 priority
        do_exc(2, 1'b1);
        prev = status_o;
        chk("R2 swi from user", prev, f_entry(32'hFFFF_FED0, 2, 1'b1));
        idle(); exc_req = 1; exc_type = 3'd4; cfg_big_endian = 0;
        wr_en = 1; wr_data = 32'h0; tick(); idle();
        chk("R11 exception over write", status_o, f_entry(prev, 4, 1'b0));
        idle(); ret_en = 1; cps_en = 1; cps_disable = 0; cps_sel_irq = 1; tick(); idle();
        chk("R11 return over cps", status_o, prev);
        idle(); cps_en = 1; cps_disable = 0; cps_sel_irq = 1;
        wr_en = 1; wr_data = 32'h0000_001F; tick(); idle();
        e = prev; e[7] = 1'b0;
        chk("R11 cps over write", status_o, e);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule